// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Frame Checker

This block checks received frames that carry a 16-bit CRC of the kind used on USB data packets. Bytes arrive one per clock on an 8-bit input, each qualified by a valid flag. A last flag marks the final byte of a frame. The two bytes that end every frame are the transmitted CRC.

A short delay buffer keeps the two most recent bytes back from the CRC generator. Only a byte that is known to be payload is folded into the running CRC register, one full byte per clock. When the last byte arrives, the buffer and that byte together hold the received CRC. A comparator sets it against the inverted recomputed value. The result is shown as one of two mutually exclusive one-cycle flags, frame good or frame bad. All state then returns to its start value for the next frame.

Top module: `crc16_frame_check`

## Requirements
- R1: After reset both result flags are low, and they stay low until a byte with the last flag set is accepted.
- R2: A frame of at least three bytes whose final two bytes equal the inverted CRC of the preceding payload raises okFlag for exactly one cycle. The flag shows in the cycle after the clock edge that accepts the last byte, and errFlag stays low.
- R3: A frame that is correct except for one flipped payload bit raises errFlag, not okFlag.
- R4: A frame that is correct except for one flipped bit in its two CRC bytes raises errFlag, not okFlag.
- R5: A frame of one or two bytes raises errFlag whatever its contents.
- R6: okFlag and errFlag are never high together. Each is high only in the cycle after a last byte is accepted, and for that one cycle only.
- R7: Every frame is checked independently of earlier frames, including a good frame that directly follows a bad or short one.
- R8: Cycles with inByteValid low change no state and leave both flags low. A frame sent with idle gaps between its bytes gets the same result as the same frame sent without gaps.
- R9: The CRC uses the polynomial x^16+x^15+x^2+1 with bits taken least-significant first. It starts from 16'hFFFF and its final value is inverted. The received CRC is sent low byte first, so the payload "123456789" gives 16'hB4C8, sent as 8'hC8 then 8'hB4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Received byte |
| inByteValid | input | 1 | inByte is valid this cycle |
| inByteLast | input | 1 | This byte ends the frame (qualified by inByteValid) |
| okFlag | output | 1 | One-cycle pulse: the frame's CRC matched |
| errFlag | output | 1 | One-cycle pulse: mismatch or frame too short |

## Verification
Two cases are the hardest to reach. One is the last byte arriving just as the two-byte holdback fills, so the final payload byte is folded in only combinationally, at the same edge as the compare. The other is frames too short to fill the holdback at all. The bench sweeps payload lengths from one byte upward, with and without idle gaps. For short payloads it flips every payload bit and every CRC bit in turn, and it sends one- and two-byte frames with several contents, each followed by a good frame.

// File: rtl/crc16_frame_pkg.sv
package crc16_frame_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CRC_W    = 16;
  // reflected form of x^16+x^15+x^2+1 for LSB-first processing
  localparam logic [CRC_W-1:0] POLY_REV = 16'hA001;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_XOR  = 16'hFFFF;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // push byte into holdback, drop oldest
    logic crcStep;   // fold oldest held byte into CRC register
    logic frameEnd;  // return CRC register to its start value
  } crcCtl_t;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY_REV = 16'hA001
) (
  input  logic [CRC_W-1:0]  crcIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crcIn;

  // one unrolled shift/xor per data bit, LSB first
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign stage[i+1] = {1'b0, stage[i][CRC_W-1:1]} ^
                        ((stage[i][0] ^ dataIn[i]) ? POLY_REV : '0);
  end

  assign crcOut = stage[DATA_W];
endmodule

// File: rtl/crc16_frame_dp.sv
module crc16_frame_dp
  import crc16_frame_pkg::*;
#(
  parameter int unsigned HOLD = CRC_W / DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inByte,
  input  crcCtl_t           ctl,
  output logic              crcMatch
);
  logic [DATA_W-1:0] hold [HOLD];
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  crcNext;
  logic [CRC_W-1:0]  rxCrc;

  crc16_byte_step #(
    .CRC_W   (CRC_W),
    .DATA_W  (DATA_W),
    .POLY_REV(POLY_REV)
  ) u_step (
    .crcIn (crcReg),
    .dataIn(hold[0]),
    .crcOut(crcNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= CRC_INIT;
      for (int j = 0; j < HOLD; j++) hold[j] <= '0;
    end else if (ctl.frameEnd) begin
      crcReg <= CRC_INIT;
    end else begin
      if (ctl.crcStep) crcReg <= crcNext;
      if (ctl.shiftIn) begin
        for (int j = 0; j < HOLD - 1; j++) hold[j] <= hold[j+1];
        hold[HOLD-1] <= inByte;
      end
    end
  end

  // received CRC: held bytes after the oldest, then the current byte; low first
  always_comb begin
    rxCrc = '0;
    for (int k = 0; k < HOLD - 1; k++) rxCrc[k*DATA_W +: DATA_W] = hold[k+1];
    rxCrc[(HOLD-1)*DATA_W +: DATA_W] = inByte;
  end

  assign crcMatch = ((crcNext ^ CRC_XOR) == rxCrc);
endmodule

// File: rtl/crc16_frame_ctl.sv
module crc16_frame_ctl
  import crc16_frame_pkg::*;
#(
  parameter int unsigned HOLD = CRC_W / DATA_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inByteValid,
  input  logic    inByteLast,
  input  logic    crcMatch,
  output crcCtl_t ctl,
  output logic    okFlag,
  output logic    errFlag
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] fillCnt;
  logic             holdFull;
  logic             endNow;

  assign holdFull = (fillCnt == CNT_W'(HOLD));
  assign endNow   = inByteValid && inByteLast;

  always_comb begin
    ctl.shiftIn  = inByteValid && !inByteLast;
    ctl.crcStep  = inByteValid && !inByteLast && holdFull;
    ctl.frameEnd = endNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      okFlag  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      okFlag  <= endNow && holdFull && crcMatch;
      errFlag <= endNow && !(holdFull && crcMatch);
      if (endNow)                         fillCnt <= '0;
      else if (ctl.shiftIn && !holdFull)  fillCnt <= fillCnt + 1'b1;
    end
  end
endmodule

// File: rtl/crc16_frame_check.sv
module crc16_frame_check
  import crc16_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inByteValid,
  input  logic       inByteLast,
  output logic       okFlag,
  output logic       errFlag
);
  localparam int unsigned HOLD = CRC_W / DATA_W;

  crcCtl_t ctl;
  logic    crcMatch;

  crc16_frame_ctl #(.HOLD(HOLD)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .inByteValid(inByteValid),
    .inByteLast (inByteLast),
    .crcMatch   (crcMatch),
    .ctl        (ctl),
    .okFlag     (okFlag),
    .errFlag    (errFlag)
  );

  crc16_frame_dp #(.HOLD(HOLD)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .ctl     (ctl),
    .crcMatch(crcMatch)
  );
endmodule

// File: rtl/crc16_frame_check_chk.sv
module crc16_frame_check_chk (
  input logic clk,
  input logic rstN,
  input logic inByteValid,
  input logic inByteLast,
  input logic okFlag,
  input logic errFlag
);
  // own count of bytes seen in the current frame, saturating at 2
  logic [1:0] seenCnt;
  always_ff @(posedge clk) begin
    if (!rstN) seenCnt <= '0;
    else if (inByteValid && inByteLast) seenCnt <= '0;
    else if (inByteValid && seenCnt != 2'd2) seenCnt <= seenCnt + 1'b1;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(okFlag && errFlag)); // R6
  AST_OK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    okFlag |-> $past(inByteValid && inByteLast)); // R2
  AST_ERR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(inByteValid && inByteLast)); // R6
  AST_SHORT_IS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (inByteValid && inByteLast && seenCnt != 2'd2) |=> errFlag); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inByteValid |=> (!okFlag && !errFlag)); // R8
endmodule

bind crc16_frame_check crc16_frame_check_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inByteValid(inByteValid),
  .inByteLast (inByteLast),
  .okFlag     (okFlag),
  .errFlag    (errFlag)
);

// File: tb/crc16_frame_check_tb.sv
`timescale 1ns/1ps
module crc16_frame_check_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inByte = '0;
  logic       inByteValid = 1'b0;
  logic       inByteLast = 1'b0;
  logic       okFlag, errFlag;

  int nChk = 0;
  int nErr = 0;
  logic [7:0] frm [64];

  always #2.5 clk = ~clk;

  crc16_frame_check u_dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inByteValid(inByteValid),
    .inByteLast(inByteLast), .okFlag(okFlag), .errFlag(errFlag)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!cond) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // CRC over frm[0..len-1]: reflected x^16+x^15+x^2+1, init FFFF, not inverted here
  function automatic logic [15:0] crcOf(input int len);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = r[0] ^ frm[i][b];
        r = r >> 1;
        if (fb) r = r ^ 16'hA001;
      end
    return r;
  endfunction

  task automatic buildFrame(input int p, input int seed);
    logic [15:0] tx;
    for (int i = 0; i < p; i++) frm[i] = 8'((i * 37 + seed * 11 + 5) ^ (seed << 3));
    tx = ~crcOf(p);
    frm[p]   = tx[7:0];
    frm[p+1] = tx[15:8];
  endtask

  task automatic sendFrame(input int n, input int gap, input bit expOk,
                           input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inByte = frm[i]; inByteValid = 1'b1; inByteLast = (i == n - 1);
      if (i != n - 1)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          inByteValid = 1'b0; inByteLast = 1'b0; inByte = 8'hA5;
          check(!okFlag && !errFlag, "R8", "flag during gap", {okFlag, errFlag}, 0);
        end
    end
    @(negedge clk);
    inByteValid = 1'b0; inByteLast = 1'b0;
    check(okFlag == expOk, req, "okFlag", okFlag, expOk);
    check(errFlag == !expOk, req, "errFlag", errFlag, !expOk);
    @(negedge clk);
    check(!okFlag && !errFlag, "R6", "flag held past one cycle", {okFlag, errFlag}, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!okFlag && !errFlag, "R1", "flags in reset", {okFlag, errFlag}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!okFlag && !errFlag, "R1", "flags after reset", {okFlag, errFlag}, 0);

    // anchor on the known check value
    for (int i = 0; i < 9; i++) frm[i] = 8'(8'h31 + i);
    check(crcOf(9) == 16'h4B37, "R9", "bench crc of 123456789", ~crcOf(9), 16'hB4C8);
    frm[9] = 8'hC8; frm[10] = 8'hB4;
    sendFrame(11, 0, 1'b1, "R9");

    // good frames over a length sweep, with and without gaps
    for (int p = 1; p <= 24; p++) begin
      buildFrame(p, p);
      sendFrame(p + 2, 0, 1'b1, "R2");
      sendFrame(p + 2, p % 3 + 1, 1'b1, "R8");
    end

    // every payload bit flipped for short payloads
    for (int p = 1; p <= 4; p++)
      for (int bit_i = 0; bit_i < p * 8; bit_i++) begin
        buildFrame(p, bit_i + 3);
        frm[bit_i / 8][bit_i % 8] = ~frm[bit_i / 8][bit_i % 8];
        sendFrame(p + 2, 0, 1'b0, "R3");
      end

    // every CRC bit flipped, each followed by a good frame
    for (int p = 1; p <= 3; p++)
      for (int cb = 0; cb < 16; cb++) begin
        buildFrame(p, cb + 50);
        frm[p + cb / 8][cb % 8] = ~frm[p + cb / 8][cb % 8];
        sendFrame(p + 2, cb % 2, 1'b0, "R4");
        buildFrame(p, cb + 50);
        sendFrame(p + 2, 0, 1'b1, "R7");
      end

    // short frames, including ones whose bytes look like a CRC of nothing
    for (int s = 0; s < 8; s++) begin
      frm[0] = 8'(s * 29); frm[1] = 8'(s * 71 + 3);
      if (s == 0) begin frm[0] = 8'h00; frm[1] = 8'h00; end
      sendFrame(1, 0, 1'b0, "R5");
      sendFrame(2, s % 2, 1'b0, "R5");
      buildFrame(s + 1, s);
      sendFrame(s + 3, 0, 1'b1, "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule